// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block sits next to a program counter. It replays a stretch of code a set number of times, so the program needs no compare-and-branch instructions. Software arms it with a one-cycle start pulse. The pulse carries an 8-bit pass count, the address of the first instruction of the body, the address of the last instruction, and a flag that chooses between repeating a block and repeating a single instruction. After that, the sequencer watches the fetch address on every cycle. When the fetch reaches the point where a pass ends and more passes remain, it presents a next-PC override in the same cycle. The jump back therefore costs no extra cycle.

A pass count of zero gives the largest run, 256 passes, and never an empty loop. In block mode, the override sends the PC from the last instruction back to the first one. In single-instruction mode, the override holds the PC on the first-instruction address until that address has been fetched the programmed number of times. Interrupts are masked for the whole single-instruction run. After the final pass there is no override, so the PC falls through to the next address and the sequencer goes idle. A start pulse that arrives while a run is in progress is dropped.

The controller has three states: IDLE, RUN_BLOCK and RUN_SINGLE. It has four named transitions:
- ACCEPT: IDLE to RUN_BLOCK or RUN_SINGLE, on a start pulse.
- WRAP: RUN_BLOCK to itself, or HOLD: RUN_SINGLE to itself, on a pass that is not the last.
- EXIT: RUN_BLOCK or RUN_SINGLE to IDLE, on the final pass.

Top module: `hwloop_seq`

## Requirements
- R1: While reset is applied and afterwards until a start pulse, loop_active_o, redirect_o and irq_inhibit_o are all 0.
- R2: In block mode, a fetch of the captured last-instruction address while more than one pass remains asserts redirect_o in the same cycle, with redirect_pc_o equal to the captured first-instruction address. Any other fetch address gives no redirect.
- R3: A programmed count N from 1 to 255 gives exactly N passes. A count of 0 gives 256 passes.
- R4: On the final pass, redirect_o stays 0, so the PC falls through to the pass-end address plus one. loop_active_o is 0 from the following cycle.
- R5: In single-instruction mode, the first-instruction address is fetched N times in a row, held by redirect_o with redirect_pc_o equal to that address. The last-instruction input is ignored.
- R6: irq_inhibit_o is 1 exactly while a single-instruction run is active. It is 0 during block runs and while idle.
- R7: A start pulse received while loop_active_o is 1 has no effect on the count, the addresses or the mode of the run in progress.
- R8: A start pulse while idle makes loop_active_o 1 from the next cycle, and the values present with the pulse are captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that arms a run |
| single_i | input | 1 | 1 selects single-instruction repeat, 0 selects block repeat |
| count_i | input | CNT_W | Pass count, 0 meaning 2^CNT_W |
| lo_addr_i | input | AW | Address of the first instruction of the body |
| hi_addr_i | input | AW | Address of the last instruction of the body |
| fetch_addr_i | input | AW | Address being fetched this cycle |
| redirect_o | output | 1 | Next-PC override is valid this cycle |
| redirect_pc_o | output | AW | Next-PC value when redirect_o is 1 |
| loop_active_o | output | 1 | A run is in progress |
| irq_inhibit_o | output | 1 | Interrupts must be masked |

## Verification
The bench models a program counter that steps by one unless it is redirected, and it compares all four outputs with a behavioural model on every cycle. Block runs with counts of 1, 3 and 0 separate an off-by-one in the pass counter from a wrong treatment of zero. Single-instruction runs with counts of 5 and 0 show whether the PC is held, rather than wrapped to the last-instruction address, and whether interrupts are masked. A run that receives a second start pulse carrying different addresses and count shows whether a busy sequencer really drops the pulse.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_RUN_BLOCK  = 2'd1,
        ST_RUN_SINGLE = 2'd2
    } loop_state_e;
endpackage

// File: rtl/hwloop_iter_ctr.sv
module hwloop_iter_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W:0]   rem_o,
    output logic             last_o
);
    localparam logic [CNT_W:0] MAX_PASSES = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W:0] ONE        = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W:0] rem_q;
    logic [CNT_W:0] load_ext;

    // a zero count stands for the largest run
    assign load_ext = (load_val_i == '0) ? MAX_PASSES : {1'b0, load_val_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= load_ext;
        end else if (dec_i && rem_q != '0) begin
            rem_q <= rem_q - ONE;
        end
    end

    assign rem_o  = rem_q;
    assign last_o = (rem_q == ONE);

    // R3: zero loads the maximum pass count
    a_r3_zero_means_max: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i == '0) |=> (rem_o == MAX_PASSES));

    // R3: each counted pass removes exactly one
    a_r3_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && rem_o > ONE) |=> (rem_o == $past(rem_o) - ONE));
endmodule

// File: rtl/hwloop_addr_match.sv
module hwloop_addr_match #(
    parameter int AW = 16
) (
    input  logic          armed_i,
    input  logic          single_i,
    input  logic [AW-1:0] lo_addr_i,
    input  logic [AW-1:0] hi_addr_i,
    input  logic [AW-1:0] fetch_addr_i,
    output logic          pass_end_o
);
    logic [AW-1:0] end_point;

    // a single-instruction body ends where it starts
    assign end_point  = single_i ? lo_addr_i : hi_addr_i;
    assign pass_end_o = armed_i && (fetch_addr_i == end_point);
endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
    import hwloop_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int AW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             single_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [AW-1:0]    lo_addr_i,
    input  logic [AW-1:0]    hi_addr_i,
    input  logic [AW-1:0]    fetch_addr_i,
    output logic             redirect_o,
    output logic [AW-1:0]    redirect_pc_o,
    output logic             loop_active_o,
    output logic             irq_inhibit_o
);
    loop_state_e   state_q, state_d;
    logic [AW-1:0] lo_q, hi_q;
    logic          accept;
    logic          running;
    logic          pass_end;
    logic          last_pass;
    logic [CNT_W:0] rem;

    assign running = (state_q != ST_IDLE);
    assign accept  = (state_q == ST_IDLE) && start_i;

    // capture the body bounds on ACCEPT only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (accept) begin
            lo_q <= lo_addr_i;
            hi_q <= hi_addr_i;
        end
    end

    hwloop_addr_match #(.AW(AW)) u_match (
        .armed_i      (running),
        .single_i     (state_q == ST_RUN_SINGLE),
        .lo_addr_i    (lo_q),
        .hi_addr_i    (hi_q),
        .fetch_addr_i (fetch_addr_i),
        .pass_end_o   (pass_end)
    );

    hwloop_iter_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (count_i),
        .dec_i      (pass_end),
        .rem_o      (rem),
        .last_o     (last_pass)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: ACCEPT, WRAP, HOLD, EXIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = single_i ? ST_RUN_SINGLE : ST_RUN_BLOCK;
            end
            ST_RUN_BLOCK, ST_RUN_SINGLE: begin
                if (pass_end && last_pass) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        redirect_o    = 1'b0;
        loop_active_o = 1'b0;
        irq_inhibit_o = 1'b0;
        redirect_pc_o = lo_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN_BLOCK: begin
                loop_active_o = 1'b1;
                redirect_o    = pass_end && !last_pass;
            end
            ST_RUN_SINGLE: begin
                loop_active_o = 1'b1;
                irq_inhibit_o = 1'b1;
                redirect_o    = pass_end && !last_pass;
            end
            default: ;
        endcase
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_active_o |-> (!redirect_o && !irq_inhibit_o));

    a_r2_redirect_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (loop_active_o && pass_end));

    a_r4_final_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_active_o && pass_end && last_pass) |=> !loop_active_o);

    a_r6_inhibit_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        irq_inhibit_o |-> loop_active_o);

    a_r7_busy_start_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_active_o && start_i && !pass_end) |=> ($stable(rem) && loop_active_o && $stable(lo_q)));

    a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_active_o && start_i) |=> loop_active_o);
endmodule

// File: tb/sim_hwloop_seq.sv
module sim_hwloop_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;
    localparam int AW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, single_i = 1'b0;
    logic [CNT_W-1:0] count_i = '0;
    logic [AW-1:0] lo_addr_i = '0, hi_addr_i = '0, fetch_addr_i = '0;
    logic redirect_o, loop_active_o, irq_inhibit_o;
    logic [AW-1:0] redirect_pc_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    hwloop_seq #(.CNT_W(CNT_W), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .single_i(single_i),
        .count_i(count_i), .lo_addr_i(lo_addr_i), .hi_addr_i(hi_addr_i),
        .fetch_addr_i(fetch_addr_i), .redirect_o(redirect_o),
        .redirect_pc_o(redirect_pc_o), .loop_active_o(loop_active_o),
        .irq_inhibit_o(irq_inhibit_o)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;
    // reference model: 0 idle, 1 block, 2 single
    int m_mode = 0, m_rem = 0, m_lo = 0, m_hi = 0;
    int pc = 0;

    task automatic check(input string tag, input bit ok, input string got, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %s expected %s", tag, got, exp);
        end
    endtask

    // one cycle: inputs already driven after a falling edge
    task automatic step(input string tag);
        int  match;
        bit  e_act, e_inh, e_hit, e_red;
        bit  ok;
        #1;
        match = (m_mode == 2) ? m_lo : m_hi;
        e_act = (m_mode != 0);
        e_inh = (m_mode == 2);
        e_hit = e_act && (pc == match);
        e_red = e_hit && (m_rem > 1);
        ok = (loop_active_o == e_act) && (irq_inhibit_o == e_inh) && (redirect_o == e_red)
             && (!e_red || int'(redirect_pc_o) == m_lo);
        check(tag, ok,
              $sformatf("act=%0b inh=%0b red=%0b pc=%0h", loop_active_o, irq_inhibit_o, redirect_o, redirect_pc_o),
              $sformatf("act=%0b inh=%0b red=%0b pc=%0h", e_act, e_inh, e_red, m_lo));
        @(posedge clk);
        if (m_mode == 0) begin
            if (start_i) begin
                m_mode = single_i ? 2 : 1;
                m_rem  = (count_i == 0) ? 256 : int'(count_i);
                m_lo   = int'(lo_addr_i);
                m_hi   = int'(hi_addr_i);
            end
        end else if (e_hit) begin
            if (m_rem > 1) m_rem--;
            else begin m_mode = 0; m_rem = 0; end
        end
        pc = e_red ? m_lo : ((pc + 1) & 16'hFFFF);
        @(negedge clk);
        fetch_addr_i = pc[AW-1:0];
    endtask

    task automatic run_loop(input string tag, input bit sgl, input int cnt, input int lo,
                            input int hi, input int pc0, input bit poke, output int visits);
        int guard = 0;
        int prev_mode;
        pc = pc0;
        fetch_addr_i = pc[AW-1:0];
        visits = 0;
        single_i = sgl; count_i = cnt[CNT_W-1:0];
        lo_addr_i = lo[AW-1:0]; hi_addr_i = hi[AW-1:0];
        start_i = 1'b1;
        step({tag, " R8 accept"});
        start_i = 1'b0;
        while ((m_mode != 0 || pc <= hi) && guard < 3000) begin
            if (poke && guard == 2) begin
                start_i = 1'b1; count_i = 8'd1; single_i = ~sgl;
                lo_addr_i = 16'h0200; hi_addr_i = 16'h0201;
            end
            if (m_mode != 0 && pc == ((m_mode == 2) ? m_lo : m_hi)) visits++;
            prev_mode = m_mode;
            step(tag);
            start_i = 1'b0;
            if (prev_mode != 0 && m_mode == 0)
                check({tag, " R4 fall-through"}, pc == hi + 1,
                      $sformatf("%0h", pc), $sformatf("%0h", hi + 1));
            guard++;
        end
        repeat (2) step({tag, " R1 idle after"});
    endtask

    initial begin
        int v;
        fetch_addr_i = 16'h0000;
        repeat (3) begin
            @(negedge clk);
            check("R1 in reset", !loop_active_o && !redirect_o && !irq_inhibit_o,
                  $sformatf("%0b%0b%0b", loop_active_o, redirect_o, irq_inhibit_o), "000");
        end
        rst_n = 1'b1;
        repeat (3) step("R1 after reset");

        run_loop("R2 block n3", 1'b0, 3, 16'h10, 16'h13, 16'h0C, 1'b0, v);
        check("R3 block count 3", v == 3, $sformatf("%0d", v), "3");

        run_loop("R3 block n1", 1'b0, 1, 16'h30, 16'h34, 16'h2E, 1'b0, v);
        check("R3 block count 1", v == 1, $sformatf("%0d", v), "1");

        run_loop("R3 block n0", 1'b0, 0, 16'h40, 16'h42, 16'h3F, 1'b0, v);
        check("R3 block count 0", v == 256, $sformatf("%0d", v), "256");

        run_loop("R5 single n5", 1'b1, 5, 16'h20, 16'h20, 16'h1E, 1'b0, v);
        check("R5 single count 5", v == 5, $sformatf("%0d", v), "5");

        run_loop("R6 single n0", 1'b1, 0, 16'h50, 16'h50, 16'h4D, 1'b0, v);
        check("R6 single count 0", v == 256, $sformatf("%0d", v), "256");

        run_loop("R7 busy start", 1'b0, 4, 16'h60, 16'h62, 16'h5E, 1'b1, v);
        check("R7 busy start ignored", v == 4, $sformatf("%0d", v), "4");

        run_loop("R7 busy start single", 1'b1, 3, 16'h70, 16'h70, 16'h6F, 1'b1, v);
        check("R7 busy start ignored single", v == 3, $sformatf("%0d", v), "3");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule